// File: doc/BRIEF.md
# Ring Node Frame Router

This block sits between the line decoder and the line encoder of a slave node on a cascaded communication ring. Each decoded frame is 40 bits wide and carries an origin tag, a three-bit node address, a four-bit command and a 32-bit payload. For each arriving frame the router decides whether it is for this node, in which case it goes to the application or to the synchronisation engine, or whether it travels on around the ring. It may do both.

Three transmit sources feed the line: the node's own application, its synchronisation engine, and the pass-through traffic from upstream. Each source has its own queue, so any of them can start a frame at any moment without colliding with the others. A small arbiter picks the next frame whenever the line is free. At start-up a test frame travels around the ring and gives every node its address. Each node stores the address it finds in the frame and sends the frame on with that address raised by one.

Top module: `ring_frame_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, the router clears `line_valid`, `app_dlv_valid`, `sync_dlv_valid`, `node_id` and the three drop counters to zero.
- R2: Frame layout is bit 39 origin tag (1 = master, 0 = slave), bits 38:36 address, bits 35:32 command, bits 31:0 payload. A frame the node sends from its application or sync source carries tag 0, the node's current `node_id`, and the given command and payload.
- R3: A master frame whose address equals `node_id` and whose command is not 15 is delivered one cycle later and is not forwarded. Commands 1 to 7 go to the sync port and every other command goes to the application port.
- R4: A master frame with address 0 (broadcast) and a command other than 15 is delivered under the same command rule as R3 and is also forwarded unchanged.
- R5: A master frame addressed to another node is forwarded unchanged and is not delivered.
- R6: A frame with tag 0 is always forwarded unchanged and never delivered, whatever its address or command.
- R7: A master frame with command 15 (test frame) is not delivered. It makes `node_id` equal to its address field from the next cycle on, and it is forwarded with the address incremented modulo 8.
- R8: When the line is free and the sync queue holds a frame, the sync frame goes out ahead of the other queues.
- R9: When the sync queue is empty and both the pass-through and application queues hold frames, the two queues alternate. Pass-through goes first after reset.
- R10: Once `line_valid` is high, `line_frame` stays unchanged until a cycle in which `line_ready` is high.
- R11: Each queue holds `DEPTH` frames. A push into a queue that was full before the edge is dropped, even if a pop happens in the same cycle, and that queue's drop counter increments and wraps at `CNT_W` bits.
- R12: Each queue keeps arrival order. A frame pushed at one edge can appear on `line_frame` at the next edge at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A decoded frame is present this cycle |
| rx_frame | input | 40 | Decoded received frame |
| app_tx_valid | input | 1 | Application pushes a frame |
| app_tx_cmd | input | 4 | Command of the application frame |
| app_tx_data | input | 32 | Payload of the application frame |
| sync_tx_valid | input | 1 | Sync engine pushes a frame |
| sync_tx_cmd | input | 4 | Command of the sync frame |
| sync_tx_data | input | 32 | Payload of the sync frame |
| line_ready | input | 1 | Encoder takes the presented frame this cycle |
| line_valid | output | 1 | A frame is presented to the encoder |
| line_frame | output | 40 | Frame presented to the encoder |
| app_dlv_valid | output | 1 | Frame delivered to the application |
| app_dlv_frame | output | 40 | Frame delivered to the application |
| sync_dlv_valid | output | 1 | Frame delivered to the sync engine |
| sync_dlv_frame | output | 40 | Frame delivered to the sync engine |
| node_id | output | 3 | Address given by the last test frame |
| ovf_sync | output | CNT_W | Drop count of the sync queue |
| ovf_pass | output | CNT_W | Drop count of the pass-through queue |
| ovf_app | output | CNT_W | Drop count of the application queue |

## Verification
The hardest case to reach from the ports is a push into a queue that is full while the arbiter pops that same queue in the same cycle, since the drop must still happen. The stimulus gets there by holding `line_ready` low until a queue fills, then lowering it only at random while all three sources keep pushing. The random phase also sends test frames with random addresses, so hits, broadcasts and address wrap-around occur against a `node_id` that keeps changing.

// File: rtl/rnr_pkg.sv
// Shared frame layout and queue indices for the ring node frame router.
// Assumes a fixed 40-bit frame: tag, 3-bit address, 4-bit command, payload.
package rnr_pkg;
    localparam int ID_W    = 3;
    localparam int CMD_W   = 4;
    localparam int DATA_W  = 32;
    localparam int FRAME_W = 1 + ID_W + CMD_W + DATA_W;
    localparam int NQ      = 3;
    localparam int Q_SYNC  = 0;
    localparam int Q_PASS  = 1;
    localparam int Q_APP   = 2;

    localparam logic [CMD_W-1:0] CMD_TEST = 4'hF;
    localparam logic [ID_W-1:0]  ID_BCAST = 3'd0;

    typedef struct packed {
        logic              tag;
        logic [ID_W-1:0]   id;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/rnr_fifo.sv
// Synchronous frame queue with a drop counter.
// A push is refused whenever the queue was full before the edge, even if a
// pop happens in the same cycle. Each refused push bumps a wrapping counter.
module rnr_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 40,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     din_i,
    input  logic             pop_i,
    output logic [W-1:0]     dout_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [CNT_W-1:0] ovf_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          accept, take;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (cnt == CW'(DEPTH));
    assign empty_o = (cnt == '0);
    assign accept  = push_i && !full_o;
    assign take    = pop_i && !empty_o;
    assign dout_o  = mem[rd_ptr];

    // Store the accepted frame at the write pointer.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= din_i;
    end

    // Move the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (accept) wr_ptr <= nxt(wr_ptr);
            if (take)   rd_ptr <= nxt(rd_ptr);
            if (accept && !take)      cnt <= cnt + 1'b1;
            else if (!accept && take) cnt <= cnt - 1'b1;
        end
    end

    // Count refused pushes.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf_o <= '0;
        else if (push_i && full_o) ovf_o <= ovf_o + 1'b1;
    end

    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    p_drop_stays_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && full_o && !pop_i |=> full_o);
    p_ovf_moves_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && full_o |=> ovf_o != $past(ovf_o));
endmodule

// File: rtl/rnr_rx_steer.sv
// Receive steering: decides delivery and forwarding of each decoded frame and
// keeps the node address taken from the start-up test frame.
// Assumes at most one received frame per cycle; delivery outputs are registered.
module rnr_rx_steer
    import rnr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid_i,
    input  logic [FRAME_W-1:0] rx_frame_i,
    output logic               fwd_push_o,
    output logic [FRAME_W-1:0] fwd_frame_o,
    output logic               app_valid_o,
    output logic [FRAME_W-1:0] app_frame_o,
    output logic               sync_valid_o,
    output logic [FRAME_W-1:0] sync_frame_o,
    output logic [ID_W-1:0]    node_id_o
);
    frame_t rx_f;
    logic   is_test, is_sync, hit, fwd;

    // Decode the frame fields and work out where it goes.
    always_comb begin
        rx_f    = frame_t'(rx_frame_i);
        is_test = rx_f.tag && (rx_f.cmd == CMD_TEST);
        is_sync = (rx_f.cmd != '0) && !rx_f.cmd[CMD_W-1];
        hit     = rx_f.tag && !is_test &&
                  ((rx_f.id == node_id_o) || (rx_f.id == ID_BCAST));
        fwd     = !rx_f.tag || is_test || (rx_f.id != node_id_o) ||
                  (rx_f.id == ID_BCAST);
    end

    assign fwd_push_o  = rx_valid_i && fwd;
    assign fwd_frame_o = is_test ? {rx_f.tag, rx_f.id + 3'd1, rx_f.cmd, rx_f.data}
                                 : rx_frame_i;

    // Register deliveries to the application and the sync engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            app_valid_o  <= 1'b0;
            sync_valid_o <= 1'b0;
            app_frame_o  <= '0;
            sync_frame_o <= '0;
        end else begin
            app_valid_o  <= rx_valid_i && hit && !is_sync;
            sync_valid_o <= rx_valid_i && hit && is_sync;
            if (rx_valid_i && hit && !is_sync) app_frame_o  <= rx_frame_i;
            if (rx_valid_i && hit && is_sync)  sync_frame_o <= rx_frame_i;
        end
    end

    // Adopt the address carried by a test frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                    node_id_o <= '0;
        else if (rx_valid_i && is_test) node_id_o <= rx_f.id;
    end
endmodule

// File: rtl/rnr_tx_arb.sv
// Transmit arbiter: loads one frame from the queues into the line register.
// Sync wins; pass-through and application alternate. A presented frame is
// held until the encoder takes it.
module rnr_tx_arb
    import rnr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NQ-1:0]              empty_i,
    input  logic [NQ-1:0][FRAME_W-1:0] head_i,
    input  logic                       line_ready_i,
    output logic [NQ-1:0]              pop_o,
    output logic                       line_valid_o,
    output logic [FRAME_W-1:0]         line_frame_o
);
    logic          load;
    logic          app_turn;
    logic [NQ-1:0] grant;

    // Choose the queue that feeds the line register.
    always_comb begin
        load  = !line_valid_o || line_ready_i;
        grant = '0;
        if (!empty_i[Q_SYNC])                          grant[Q_SYNC] = 1'b1;
        else if (!empty_i[Q_PASS] && !empty_i[Q_APP])  grant[app_turn ? Q_APP : Q_PASS] = 1'b1;
        else if (!empty_i[Q_PASS])                     grant[Q_PASS] = 1'b1;
        else if (!empty_i[Q_APP])                      grant[Q_APP]  = 1'b1;
        pop_o = load ? grant : '0;
    end

    // Update the line register and the round-robin turn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_valid_o <= 1'b0;
            line_frame_o <= '0;
            app_turn     <= 1'b0;
        end else if (load) begin
            line_valid_o <= |grant;
            for (int q = 0; q < NQ; q++) begin
                if (grant[q]) line_frame_o <= head_i[q];
            end
            if (grant[Q_PASS]) app_turn <= 1'b1;
            if (grant[Q_APP])  app_turn <= 1'b0;
        end
    end

    p_sync_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_o[Q_PASS] || pop_o[Q_APP]) |-> empty_i[Q_SYNC]);
    p_alternate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o[Q_PASS] |=> !(pop_o[Q_PASS] && !empty_i[Q_APP]));
endmodule

// File: rtl/ring_frame_router.sv
// Ring node frame router (slave node). Steers received frames and arbitrates
// three source queues onto the line encoder.
// Assumes decoded frames arrive at most one per cycle and that the encoder
// accepts a presented frame on any cycle with line_ready high.
module ring_frame_router
    import rnr_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [39:0]        rx_frame,
    input  logic               app_tx_valid,
    input  logic [3:0]         app_tx_cmd,
    input  logic [31:0]        app_tx_data,
    input  logic               sync_tx_valid,
    input  logic [3:0]         sync_tx_cmd,
    input  logic [31:0]        sync_tx_data,
    input  logic               line_ready,
    output logic               line_valid,
    output logic [39:0]        line_frame,
    output logic               app_dlv_valid,
    output logic [39:0]        app_dlv_frame,
    output logic               sync_dlv_valid,
    output logic [39:0]        sync_dlv_frame,
    output logic [2:0]         node_id,
    output logic [CNT_W-1:0]   ovf_sync,
    output logic [CNT_W-1:0]   ovf_pass,
    output logic [CNT_W-1:0]   ovf_app
);
    logic                       fwd_push;
    logic [FRAME_W-1:0]         fwd_frame;
    logic [NQ-1:0]              q_push, q_pop, q_empty, q_full;
    logic [NQ-1:0][FRAME_W-1:0] q_din, q_head;
    logic [NQ-1:0][CNT_W-1:0]   q_ovf;

    rnr_rx_steer u_steer (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid_i   (rx_valid),
        .rx_frame_i   (rx_frame),
        .fwd_push_o   (fwd_push),
        .fwd_frame_o  (fwd_frame),
        .app_valid_o  (app_dlv_valid),
        .app_frame_o  (app_dlv_frame),
        .sync_valid_o (sync_dlv_valid),
        .sync_frame_o (sync_dlv_frame),
        .node_id_o    (node_id)
    );

    // Build the queue inputs; local frames carry slave tag and own address.
    always_comb begin
        q_push[Q_SYNC] = sync_tx_valid;
        q_din[Q_SYNC]  = {1'b0, node_id, sync_tx_cmd, sync_tx_data};
        q_push[Q_PASS] = fwd_push;
        q_din[Q_PASS]  = fwd_frame;
        q_push[Q_APP]  = app_tx_valid;
        q_din[Q_APP]   = {1'b0, node_id, app_tx_cmd, app_tx_data};
    end

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        rnr_fifo #(.DEPTH(DEPTH), .W(FRAME_W), .CNT_W(CNT_W)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (q_push[q]),
            .din_i   (q_din[q]),
            .pop_i   (q_pop[q]),
            .dout_o  (q_head[q]),
            .empty_o (q_empty[q]),
            .full_o  (q_full[q]),
            .ovf_o   (q_ovf[q])
        );
    end

    assign ovf_sync = q_ovf[Q_SYNC];
    assign ovf_pass = q_ovf[Q_PASS];
    assign ovf_app  = q_ovf[Q_APP];

    rnr_tx_arb u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .empty_i      (q_empty),
        .head_i       (q_head),
        .line_ready_i (line_ready),
        .pop_o        (q_pop),
        .line_valid_o (line_valid),
        .line_frame_o (line_frame)
    );

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid && !line_ready |=> line_valid && $stable(line_frame));
    p_slave_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_frame[39] |=> !app_dlv_valid && !sync_dlv_valid);
    p_test_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_frame[39] && rx_frame[35:32] == 4'hF |=> node_id == $past(rx_frame[38:36]));
    p_one_sink_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(app_dlv_valid && sync_dlv_valid));
    p_full_seen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_full & q_empty));
endmodule

// File: tb/tb_ring_frame_router.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random traffic, all compared
// against a queue-level reference model computed from the requirements.
module tb_ring_frame_router;
    localparam int DEPTH = 4;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic rx_valid, app_tx_valid, sync_tx_valid, line_ready;
    logic [39:0] rx_frame;
    logic [3:0]  app_tx_cmd, sync_tx_cmd;
    logic [31:0] app_tx_data, sync_tx_data;
    logic line_valid, app_dlv_valid, sync_dlv_valid;
    logic [39:0] line_frame, app_dlv_frame, sync_dlv_frame;
    logic [2:0]  node_id;
    logic [CNT_W-1:0] ovf_sync, ovf_pass, ovf_app;

    ring_frame_router #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_frame(rx_frame),
        .app_tx_valid(app_tx_valid), .app_tx_cmd(app_tx_cmd), .app_tx_data(app_tx_data),
        .sync_tx_valid(sync_tx_valid), .sync_tx_cmd(sync_tx_cmd), .sync_tx_data(sync_tx_data),
        .line_ready(line_ready), .line_valid(line_valid), .line_frame(line_frame),
        .app_dlv_valid(app_dlv_valid), .app_dlv_frame(app_dlv_frame),
        .sync_dlv_valid(sync_dlv_valid), .sync_dlv_frame(sync_dlv_frame),
        .node_id(node_id), .ovf_sync(ovf_sync), .ovf_pass(ovf_pass), .ovf_app(ovf_app)
    );

    always #2 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string phase = "R1";

    // Reference model state
    logic [39:0] qs[$], qp[$], qa[$];
    logic        m_lv, m_av, m_sv, m_rr;
    logic [39:0] m_lf, m_af, m_sf;
    logic [2:0]  m_id;
    logic [CNT_W-1:0] m_os, m_op, m_oa;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(64'(line_valid), 64'(m_lv), "line_valid");
        if (m_lv) chk(64'(line_frame), 64'(m_lf), "line_frame");
        chk(64'(app_dlv_valid), 64'(m_av), "app_dlv_valid");
        if (m_av) chk(64'(app_dlv_frame), 64'(m_af), "app_dlv_frame");
        chk(64'(sync_dlv_valid), 64'(m_sv), "sync_dlv_valid");
        if (m_sv) chk(64'(sync_dlv_frame), 64'(m_sf), "sync_dlv_frame");
        chk(64'(node_id), 64'(m_id), "node_id");
        chk(64'(ovf_sync), 64'(m_os), "ovf_sync");
        chk(64'(ovf_pass), 64'(m_op), "ovf_pass");
        chk(64'(ovf_app), 64'(m_oa), "ovf_app");
    endtask

    // One clock of the requirement model, from the inputs now driven.
    task automatic model_step();
        bit load, is_test, is_sync, hit, fwd;
        int g, ps_s, ps_p, ps_a;
        logic [39:0] f;
        load = !m_lv || line_ready;
        ps_s = qs.size(); ps_p = qp.size(); ps_a = qa.size();
        g = -1;
        if (load) begin
            if (ps_s > 0)                 g = 0;
            else if (ps_p > 0 && ps_a > 0) g = m_rr ? 2 : 1;
            else if (ps_p > 0)            g = 1;
            else if (ps_a > 0)            g = 2;
        end
        is_test = rx_frame[39] && rx_frame[35:32] == 4'hF;
        is_sync = rx_frame[35:32] >= 4'd1 && rx_frame[35:32] <= 4'd7;
        hit = rx_frame[39] && !is_test && (rx_frame[38:36] == m_id || rx_frame[38:36] == 3'd0);
        fwd = !rx_frame[39] || is_test || rx_frame[38:36] != m_id || rx_frame[38:36] == 3'd0;
        f = is_test ? {rx_frame[39], rx_frame[38:36] + 3'd1, rx_frame[35:0]} : rx_frame;
        m_av = 0; m_sv = 0;
        if (rx_valid && hit) begin
            if (is_sync) begin m_sv = 1; m_sf = rx_frame; end
            else         begin m_av = 1; m_af = rx_frame; end
        end
        if (load) begin
            m_lv = (g >= 0);
            if (g == 0) m_lf = qs.pop_front();
            if (g == 1) begin m_lf = qp.pop_front(); m_rr = 1; end
            if (g == 2) begin m_lf = qa.pop_front(); m_rr = 0; end
        end
        if (rx_valid && fwd) begin
            if (ps_p == DEPTH) m_op++; else qp.push_back(f);
        end
        if (app_tx_valid) begin
            if (ps_a == DEPTH) m_oa++; else qa.push_back({1'b0, m_id, app_tx_cmd, app_tx_data});
        end
        if (sync_tx_valid) begin
            if (ps_s == DEPTH) m_os++; else qs.push_back({1'b0, m_id, sync_tx_cmd, sync_tx_data});
        end
        if (rx_valid && is_test) m_id = rx_frame[38:36];
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        compare_all();
        rx_valid = 0; app_tx_valid = 0; sync_tx_valid = 0;
    endtask

    task automatic send_rx(input logic [39:0] fr);
        rx_valid = 1; rx_frame = fr; cyc();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        rst_n = 0; rx_valid = 0; rx_frame = '0; app_tx_valid = 0; app_tx_cmd = '0;
        app_tx_data = '0; sync_tx_valid = 0; sync_tx_cmd = '0; sync_tx_data = '0;
        line_ready = 1;
        m_lv = 0; m_av = 0; m_sv = 0; m_rr = 0; m_lf = '0; m_af = '0; m_sf = '0;
        m_id = '0; m_os = '0; m_op = '0; m_oa = '0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        phase = "R1"; compare_all();
        rst_n = 1;

        phase = "R7";   // test frame: adopt 5, forward with 6
        send_rx({1'b1, 3'd5, 4'hF, 32'hA5A5_0001}); idle(3);
        send_rx({1'b1, 3'd7, 4'hF, 32'h0000_0007}); idle(3);   // wrap to 0
        send_rx({1'b1, 3'd5, 4'hF, 32'h0000_0005}); idle(3);

        phase = "R3";
        send_rx({1'b1, 3'd5, 4'h0, 32'h1111_0000}); idle(2);
        send_rx({1'b1, 3'd5, 4'h3, 32'h2222_0000}); idle(2);
        send_rx({1'b1, 3'd5, 4'hA, 32'h3333_0000}); idle(2);

        phase = "R4";
        send_rx({1'b1, 3'd0, 4'h9, 32'h4444_0000}); idle(3);
        send_rx({1'b1, 3'd0, 4'h7, 32'h4444_0001}); idle(3);

        phase = "R5";
        send_rx({1'b1, 3'd2, 4'h0, 32'h5555_0000}); idle(3);

        phase = "R6";
        send_rx({1'b0, 3'd5, 4'h0, 32'h6666_0000}); idle(3);
        send_rx({1'b0, 3'd0, 4'hF, 32'h6666_0001}); idle(3);

        phase = "R2";
        app_tx_valid = 1; app_tx_cmd = 4'h6; app_tx_data = 32'h7777_0000; cyc(); idle(2);
        sync_tx_valid = 1; sync_tx_cmd = 4'h2; sync_tx_data = 32'h7777_0001; cyc(); idle(2);

        phase = "R8";
        line_ready = 0;
        rx_valid = 1; rx_frame = {1'b1, 3'd3, 4'h0, 32'h8888_0000};
        app_tx_valid = 1; app_tx_data = 32'h8888_0001;
        sync_tx_valid = 1; sync_tx_data = 32'h8888_0002; cyc();
        rx_valid = 1; rx_frame = {1'b1, 3'd3, 4'h0, 32'h8888_0003};
        sync_tx_valid = 1; sync_tx_data = 32'h8888_0004; cyc();
        line_ready = 1; idle(6);

        phase = "R9";
        line_ready = 0;
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1; rx_frame = {1'b0, 3'd1, 4'h0, 32'h9999_0000 + 32'(i)};
            app_tx_valid = 1; app_tx_data = 32'h9999_1000 + 32'(i); cyc();
        end
        line_ready = 1; idle(8);

        phase = "R10";
        line_ready = 0;
        app_tx_valid = 1; app_tx_data = 32'hAAAA_0000; cyc();
        idle(5); line_ready = 1; idle(3);

        phase = "R11";
        line_ready = 0;
        for (int i = 0; i < DEPTH + 4; i++) begin
            app_tx_valid = 1; app_tx_data = 32'hBBBB_0000 + 32'(i);
            sync_tx_valid = 1; sync_tx_data = 32'hBBBB_1000 + 32'(i);
            rx_valid = 1; rx_frame = {1'b0, 3'd4, 4'h1, 32'hBBBB_2000 + 32'(i)}; cyc();
        end
        // full queue pushed while the arbiter pops it
        line_ready = 1;
        sync_tx_valid = 1; sync_tx_data = 32'hBBBB_3000; cyc();
        idle(16);

        phase = "R12";
        for (int i = 0; i < 3000; i++) begin
            int c;
            line_ready   = ($urandom_range(0, 9) < 6);
            rx_valid     = ($urandom_range(0, 9) < 4);
            c = $urandom_range(0, 5);
            rx_frame = {1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
                        (c == 0) ? 4'hF : (c < 3) ? 4'($urandom_range(1, 7)) : 4'($urandom_range(8, 14)) & 4'hF,
                        32'($urandom())};
            if (c == 5) rx_frame[35:32] = 4'h0;
            app_tx_valid  = ($urandom_range(0, 9) < 3);
            app_tx_cmd    = 4'($urandom_range(0, 15));
            app_tx_data   = 32'($urandom());
            sync_tx_valid = ($urandom_range(0, 9) < 2);
            sync_tx_cmd   = 4'($urandom_range(1, 7));
            sync_tx_data  = 32'($urandom());
            cyc();
        end
        line_ready = 1; idle(20);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog %s: actual hung expected finished", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule